// File: doc/BRIEF.md
# Shared I/O register bank with write-collision policies

The block holds 128 byte-wide I/O registers that two agents share: a CPU write port and a peripheral port that reads and writes (a display engine, for example). Time runs in machine cycles of four sub-cycles, one clock each. The CPU may write only in sub-cycle 0. The peripheral may read or write in any sub-cycle.

Each register carries a collision policy. The policy sets what the peripheral observes when the CPU writes that register in the same sub-cycle as a peripheral read. For one policy it also sets whose data survives a simultaneous write. Two policy tables are built in at elaboration time, and a model-select input picks the active one. Only CPU addresses inside the I/O window consult the table. Every other CPU address is treated with the default policy.

The bank stores every CPU write at the low seven address bits. The peripheral read data is combinational from the committed register, with forwarding where a policy requires it.

Top module: `ioc_conflict_bank`

## Requirements
- R1: After reset every register reads 0x00 on the peripheral port and `phase_o` is 0.
- R2: `phase_o` counts 0,1,2,3 and wraps, advancing once per clock. A CPU write request is accepted only while `phase_o` is 0. A request in sub-cycles 1 to 3 leaves every register unchanged.
- R3: Policy code 2'b00 (read-old). A peripheral read of the written register in sub-cycle 0 returns the previous value. The new value is returned from sub-cycle 1 on.
- R4: Policy code 2'b01 (read-new). A peripheral read of the written register in sub-cycle 0 already returns the CPU data. It keeps returning it afterwards.
- R5: Policy code 2'b10 (read-OR). A peripheral read of the written register in sub-cycle 0 returns old OR new. From sub-cycle 1 it returns the pure CPU data.
- R6: Policy code 2'b11 (CPU-wins). The write commits at the end of sub-cycle 1, so reads in sub-cycles 0 and 1 return the old value and reads from sub-cycle 2 return the new value. A peripheral write to the same register in sub-cycle 1 is discarded in favour of the CPU data.
- R7: Under codes 2'b00, 2'b01 and 2'b10, a peripheral write to the register the CPU writes in the same sub-cycle is the value stored.
- R8: The table is consulted only when `(cpu_addr_i & 16'hFF80) == 16'hFF00`. Otherwise the write uses code 2'b00 and is still stored at index `cpu_addr_i[6:0]`.
- R9: With `model_sel_i`=0, index 0x0F is CPU-wins. Indices 0x47, 0x48 and 0x49 are read-OR. Indices 0x40, 0x41, 0x42, 0x43, 0x45, 0x4A and 0x4B are read-new. All others are read-old.
- R10: With `model_sel_i`=1, index 0x0F is CPU-wins and every other index is read-old.
- R11: A peripheral write that meets no CPU write to the same register is visible on the next clock. The peripheral read data follows `per_addr_i` within the same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sub-cycle clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| model_sel_i | input | 1 | Policy table select (0 first table, 1 second) |
| cpu_we_i | input | 1 | CPU write request, taken in sub-cycle 0 only |
| cpu_addr_i | input | 16 | CPU write address |
| cpu_wdata_i | input | 8 | CPU write data |
| per_addr_i | input | 7 | Peripheral register index |
| per_we_i | input | 1 | Peripheral write enable |
| per_wdata_i | input | 8 | Peripheral write data |
| per_rdata_o | output | 8 | Peripheral read data |
| phase_o | output | 2 | Current sub-cycle number |

## Verification
The bench writes one register of each policy class with old and new values whose bits only partly overlap. It then reads that register in all four sub-cycles, so read-old, read-new and read-OR give three distinct values in sub-cycle 0. Two further patterns separate CPU-wins from the peripheral-wins rule: a simultaneous write in the CPU-wins commit slot, and a simultaneous write in sub-cycle 0 to a read-new register. Writes outside the window, writes under the second model and requests off sub-cycle 0 each show that the address decode, the table select and the accept slot are wired correctly. A long random mix of both ports on colliding indices is then compared clock by clock against a behavioural model.

// File: rtl/ioc_pkg.sv
package ioc_pkg;
  localparam int unsigned IDX_W = 7;
  localparam int unsigned NREG  = 1 << IDX_W;

  typedef enum logic [1:0] {
    POL_OLD = 2'b00,
    POL_NEW = 2'b01,
    POL_OR  = 2'b10,
    POL_CPU = 2'b11
  } pol_e;

  typedef logic [NREG-1:0][1:0] pol_tbl_t;

  localparam logic [IDX_W-1:0] IDX_IFLAG = 7'h0F;
  localparam logic [IDX_W-1:0] IDX_LCTRL = 7'h40;
  localparam logic [IDX_W-1:0] IDX_LSTAT = 7'h41;
  localparam logic [IDX_W-1:0] IDX_SCRY  = 7'h42;
  localparam logic [IDX_W-1:0] IDX_SCRX  = 7'h43;
  localparam logic [IDX_W-1:0] IDX_LCMP  = 7'h45;
  localparam logic [IDX_W-1:0] IDX_PAL0  = 7'h47;
  localparam logic [IDX_W-1:0] IDX_PAL1  = 7'h48;
  localparam logic [IDX_W-1:0] IDX_PAL2  = 7'h49;
  localparam logic [IDX_W-1:0] IDX_WINY  = 7'h4A;
  localparam logic [IDX_W-1:0] IDX_WINX  = 7'h4B;

  function automatic pol_tbl_t tbl_model_a();
    pol_tbl_t t;
    for (int i = 0; i < NREG; i++) t[i] = POL_OLD;
    t[IDX_IFLAG] = POL_CPU;
    t[IDX_PAL0]  = POL_OR;
    t[IDX_PAL1]  = POL_OR;
    t[IDX_PAL2]  = POL_OR;
    t[IDX_LCTRL] = POL_NEW;
    t[IDX_LSTAT] = POL_NEW;
    t[IDX_SCRY]  = POL_NEW;
    t[IDX_SCRX]  = POL_NEW;
    t[IDX_WINY]  = POL_NEW;
    t[IDX_WINX]  = POL_NEW;
    t[IDX_LCMP]  = POL_NEW;
    return t;
  endfunction

  function automatic pol_tbl_t tbl_model_b();
    pol_tbl_t t;
    for (int i = 0; i < NREG; i++) t[i] = POL_OLD;
    t[IDX_IFLAG] = POL_CPU;
    return t;
  endfunction
endpackage

// File: rtl/ioc_phase.sv
module ioc_phase #(
  parameter int unsigned PH_W = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  output logic [PH_W-1:0] phase_o,
  output logic            slot_acc_o,
  output logic            slot_late_o
);
  logic [PH_W-1:0] ph_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ph_q <= '0;
    else         ph_q <= ph_q + 1'b1;
  end

  assign phase_o     = ph_q;
  assign slot_acc_o  = (ph_q == '0);
  assign slot_late_o = (ph_q == PH_W'(1));
endmodule

// File: rtl/ioc_policy.sv
module ioc_policy
  import ioc_pkg::*;
#(
  parameter int unsigned CPU_AW   = 16,
  parameter logic [CPU_AW-1:0] WIN_MASK = 16'hFF80,
  parameter logic [CPU_AW-1:0] WIN_BASE = 16'hFF00,
  parameter pol_tbl_t    TBL_A    = tbl_model_a(),
  parameter pol_tbl_t    TBL_B    = tbl_model_b()
) (
  input  logic              model_sel_i,
  input  logic [CPU_AW-1:0] cpu_addr_i,
  output logic [IDX_W-1:0]  idx_o,
  output pol_e              pol_o
);
  logic in_win;
  pol_e code_a, code_b;

  assign idx_o  = cpu_addr_i[IDX_W-1:0];
  assign in_win = (cpu_addr_i & WIN_MASK) == WIN_BASE;
  assign code_a = pol_e'(TBL_A[idx_o]);
  assign code_b = pol_e'(TBL_B[idx_o]);

  always_comb begin
    if (!in_win)          pol_o = POL_OLD;
    else if (model_sel_i) pol_o = code_b;
    else                  pol_o = code_a;
  end
endmodule

// File: rtl/ioc_bank.sv
module ioc_bank
  import ioc_pkg::*;
#(
  parameter int unsigned DW   = 8,
  parameter int unsigned PH_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [PH_W-1:0]  phase_i,
  input  logic             cpu_acc_i,
  input  logic [IDX_W-1:0] cpu_idx_i,
  input  logic [DW-1:0]    cpu_wdata_i,
  input  pol_e             pol_i,
  input  logic [IDX_W-1:0] per_addr_i,
  input  logic             per_we_i,
  input  logic [DW-1:0]    per_wdata_i,
  output logic [DW-1:0]    per_rdata_o
);
  logic [DW-1:0]    regs_q [NREG];
  logic             stage_vld_q;
  logic [IDX_W-1:0] stage_idx_q;
  logic [DW-1:0]    stage_dat_q;
  logic             cpu_now, stage_set, hit;
  logic [NREG-1:0]  we_vec;
  logic [DW-1:0]    wd_vec [NREG];
  logic [DW-1:0]    raw_rd;
  logic             wr_any;

  assign cpu_now   = cpu_acc_i && (pol_i != POL_CPU);
  assign stage_set = cpu_acc_i && (pol_i == POL_CPU);

  // CPU-wins writes wait one sub-cycle in a stage
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_vld_q <= 1'b0;
      stage_idx_q <= '0;
      stage_dat_q <= '0;
    end else begin
      stage_vld_q <= stage_set;
      if (stage_set) begin
        stage_idx_q <= cpu_idx_i;
        stage_dat_q <= cpu_wdata_i;
      end
    end
  end

  // priority: staged CPU > peripheral > immediate CPU
  for (genvar g = 0; g < NREG; g++) begin : g_dec
    logic st_hit, pe_hit, cp_hit;
    assign st_hit    = stage_vld_q && (stage_idx_q == IDX_W'(g));
    assign pe_hit    = per_we_i && (per_addr_i == IDX_W'(g));
    assign cp_hit    = cpu_now && (cpu_idx_i == IDX_W'(g));
    assign we_vec[g] = st_hit | pe_hit | cp_hit;
    assign wd_vec[g] = st_hit ? stage_dat_q : (pe_hit ? per_wdata_i : cpu_wdata_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NREG; i++) regs_q[i] <= '0;
    end else begin
      for (int i = 0; i < NREG; i++)
        if (we_vec[i]) regs_q[i] <= wd_vec[i];
    end
  end

  assign raw_rd = regs_q[per_addr_i];
  assign hit    = cpu_acc_i && (cpu_idx_i == per_addr_i);

  always_comb begin
    per_rdata_o = raw_rd;
    if (hit) begin
      case (pol_i)
        POL_NEW: per_rdata_o = cpu_wdata_i;
        POL_OR:  per_rdata_o = raw_rd | cpu_wdata_i;
        default: per_rdata_o = raw_rd;
      endcase
    end
  end

  assign wr_any = stage_vld_q | per_we_i | cpu_now;

  AST_ACC_SLOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_acc_i |-> (phase_i == '0)); // R2

  AST_STAGE_SLOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stage_vld_q |-> (phase_i == PH_W'(1))); // R6

  AST_STAGE_ONCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stage_vld_q |=> !stage_vld_q); // R6

  AST_CPU_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stage_vld_q && per_we_i && per_addr_i == stage_idx_q)
    |=> regs_q[$past(stage_idx_q)] == $past(stage_dat_q)); // R6

  AST_PER_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_now && per_we_i && per_addr_i == cpu_idx_i)
    |=> regs_q[$past(cpu_idx_i)] == $past(per_wdata_i)); // R7

  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_any |=> regs_q[$past(per_addr_i)] == $past(raw_rd)); // R11
endmodule

// File: rtl/ioc_conflict_bank.sv
module ioc_conflict_bank
  import ioc_pkg::*;
#(
  parameter int unsigned DW     = 8,
  parameter int unsigned CPU_AW = 16,
  parameter int unsigned PH_W   = 2,
  parameter logic [CPU_AW-1:0] WIN_MASK = 16'hFF80,
  parameter logic [CPU_AW-1:0] WIN_BASE = 16'hFF00,
  parameter pol_tbl_t    TBL_A  = tbl_model_a(),
  parameter pol_tbl_t    TBL_B  = tbl_model_b()
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              model_sel_i,
  input  logic              cpu_we_i,
  input  logic [CPU_AW-1:0] cpu_addr_i,
  input  logic [DW-1:0]     cpu_wdata_i,
  input  logic [IDX_W-1:0]  per_addr_i,
  input  logic              per_we_i,
  input  logic [DW-1:0]     per_wdata_i,
  output logic [DW-1:0]     per_rdata_o,
  output logic [PH_W-1:0]   phase_o
);
  logic             slot_acc, slot_late, cpu_acc;
  logic [IDX_W-1:0] cpu_idx;
  pol_e             pol;

  ioc_phase #(.PH_W(PH_W)) u_phase (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .phase_o    (phase_o),
    .slot_acc_o (slot_acc),
    .slot_late_o(slot_late)
  );

  ioc_policy #(
    .CPU_AW  (CPU_AW),
    .WIN_MASK(WIN_MASK),
    .WIN_BASE(WIN_BASE),
    .TBL_A   (TBL_A),
    .TBL_B   (TBL_B)
  ) u_policy (
    .model_sel_i(model_sel_i),
    .cpu_addr_i (cpu_addr_i),
    .idx_o      (cpu_idx),
    .pol_o      (pol)
  );

  assign cpu_acc = cpu_we_i && slot_acc;

  ioc_bank #(.DW(DW), .PH_W(PH_W)) u_bank (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .phase_i    (phase_o),
    .cpu_acc_i  (cpu_acc),
    .cpu_idx_i  (cpu_idx),
    .cpu_wdata_i(cpu_wdata_i),
    .pol_i      (pol),
    .per_addr_i (per_addr_i),
    .per_we_i   (per_we_i),
    .per_wdata_i(per_wdata_i),
    .per_rdata_o(per_rdata_o)
  );

  AST_LATE_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_acc |=> slot_late); // R2
endmodule

// File: tb/ioc_conflict_bank_test.sv
module ioc_conflict_bank_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        msel = 1'b0;
  logic        c_we = 1'b0;
  logic [15:0] c_addr = '0;
  logic [7:0]  c_wd = '0;
  logic [6:0]  p_addr = '0;
  logic        p_we = 1'b0;
  logic [7:0]  p_wd = '0;
  logic [7:0]  rdata;
  logic [1:0]  phase;

  int checks = 0;
  int errors = 0;

  logic [7:0] m_mem [128];
  int         m_ph = 0;
  bit         m_pv = 0;
  logic [6:0] m_pi = '0;
  logic [7:0] m_pd = '0;

  always #5 clk = ~clk;

  ioc_conflict_bank uut (
    .clk_i(clk), .rst_ni(rst_ni), .model_sel_i(msel),
    .cpu_we_i(c_we), .cpu_addr_i(c_addr), .cpu_wdata_i(c_wd),
    .per_addr_i(p_addr), .per_we_i(p_we), .per_wdata_i(p_wd),
    .per_rdata_o(rdata), .phase_o(phase)
  );

  function automatic int pol_of(bit model, logic [15:0] a);
    logic [6:0] i;
    if ((a & 16'hFF80) != 16'hFF00) return 0;
    i = a[6:0];
    if (i == 7'h0F) return 3;
    if (model) return 0;
    case (i)
      7'h47, 7'h48, 7'h49: return 2;
      7'h40, 7'h41, 7'h42, 7'h43, 7'h45, 7'h4A, 7'h4B: return 1;
      default: return 0;
    endcase
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // called right after a falling edge with inputs set; ends at the next falling edge
  task automatic step(string tag);
    bit acc;
    int pol;
    logic [6:0] ci;
    logic [7:0] ex;
    acc = c_we && (m_ph == 0);
    pol = pol_of(msel, c_addr);
    ci  = c_addr[6:0];
    ex  = m_mem[p_addr];
    if (acc && ci == p_addr) begin
      if (pol == 1) ex = c_wd;
      if (pol == 2) ex = m_mem[ci] | c_wd;
    end
    #1;
    chk(rdata === ex, tag, rdata, ex);
    chk(phase === 2'(m_ph), "R2", phase, m_ph);
    @(posedge clk);
    if (acc && pol != 3) m_mem[ci] = c_wd;
    if (p_we) m_mem[p_addr] = p_wd;
    if (m_pv) m_mem[m_pi] = m_pd;
    m_pv = acc && (pol == 3);
    if (m_pv) begin m_pi = ci; m_pd = c_wd; end
    m_ph = (m_ph + 1) % 4;
    @(negedge clk);
  endtask

  task automatic idle_inputs();
    c_we = 1'b0; p_we = 1'b0;
  endtask

  task automatic align0();
    idle_inputs();
    while (m_ph != 0) step("R2");
  endtask

  task automatic preload(logic [6:0] idx, logic [7:0] v);
    idle_inputs();
    p_we = 1'b1; p_addr = idx; p_wd = v;
    step("R11");
    p_we = 1'b0;
    step("R11");
  endtask

  // CPU write in sub-cycle 0, peripheral reads the same index in sub-cycles 0..3
  task automatic collide(logic [15:0] a, logic [7:0] oldv, logic [7:0] newv, string tag);
    preload(a[6:0], oldv);
    align0();
    c_we = 1'b1; c_addr = a; c_wd = newv; p_addr = a[6:0];
    step(tag);
    c_we = 1'b0;
    for (int k = 1; k < 4; k++) step(tag);
  endtask

  initial begin
    for (int i = 0; i < 128; i++) m_mem[i] = '0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // R1: reset state
    for (int i = 0; i < 8; i++) begin
      p_addr = 7'(i * 17);
      step("R1");
    end
    p_addr = 7'h47;
    #1 chk(rdata === 8'h00, "R1", rdata, 0);

    // R9 model 0 classes, R3..R6 per policy
    msel = 1'b0;
    collide(16'hFF01, 8'h3C, 8'hA5, "R3");
    collide(16'hFF40, 8'h3C, 8'hA5, "R4");
    collide(16'hFF4B, 8'h11, 8'h82, "R9");
    collide(16'hFF47, 8'h3C, 8'hA5, "R5");
    collide(16'hFF49, 8'h0F, 8'hF0, "R9");
    collide(16'hFF0F, 8'h3C, 8'hA5, "R6");

    // R6: simultaneous write in the commit slot, CPU data kept
    preload(7'h0F, 8'h01);
    align0();
    c_we = 1'b1; c_addr = 16'hFF0F; c_wd = 8'h5A; p_addr = 7'h0F;
    step("R6");
    c_we = 1'b0; p_we = 1'b1; p_wd = 8'hC3;
    step("R6");
    p_we = 1'b0;
    step("R6");
    #0 chk(m_mem[7'h0F] === 8'h5A, "R6", m_mem[7'h0F], 8'h5A);

    // R7: simultaneous write in sub-cycle 0 on a read-new register, peripheral kept
    preload(7'h42, 8'h00);
    align0();
    c_we = 1'b1; c_addr = 16'hFF42; c_wd = 8'h77; p_addr = 7'h42; p_we = 1'b1; p_wd = 8'h99;
    step("R7");
    idle_inputs();
    step("R7");

    // R8: outside the window, stored at low bits with read-old
    collide(16'h8047, 8'h3C, 8'hA5, "R8");
    collide(16'hFE40, 8'h0C, 8'h30, "R8");

    // R10: second model
    msel = 1'b1;
    collide(16'hFF47, 8'h3C, 8'hA5, "R10");
    collide(16'hFF40, 8'h3C, 8'hA5, "R10");
    collide(16'hFF0F, 8'h3C, 8'hA5, "R10");
    msel = 1'b0;

    // R2: requests off sub-cycle 0 are dropped
    preload(7'h43, 8'h44);
    align0();
    step("R2");
    c_we = 1'b1; c_addr = 16'hFF43; c_wd = 8'hEE; p_addr = 7'h43;
    step("R2"); step("R2"); step("R2");
    c_we = 1'b0;
    step("R2");

    // R11: peripheral read follows address within the clock
    preload(7'h10, 8'h5C);
    p_addr = 7'h10;
    #1 chk(rdata === 8'h5C, "R11", rdata, 8'h5C);
    p_addr = 7'h43;
    #1 chk(rdata === 8'h44, "R11", rdata, 8'h44);
    #0;
    step("R11");

    // random mix on colliding indices
    for (int n = 0; n < 3000; n++) begin
      logic [6:0] pick [8];
      pick = '{7'h0F, 7'h40, 7'h45, 7'h47, 7'h48, 7'h01, 7'h4A, 7'h20};
      if (($urandom % 64) == 0) msel = ~msel;
      c_we   = ($urandom % 2) == 1;
      c_addr = {(($urandom % 4) == 0) ? 9'h100 : 9'h1FE, pick[$urandom % 8]};
      c_wd   = 8'($urandom);
      p_we   = ($urandom % 3) == 0;
      p_addr = (($urandom % 2) == 0) ? c_addr[6:0] : pick[$urandom % 8];
      p_wd   = 8'($urandom);
      step("R11");
    end
    idle_inputs();
    step("R11");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog expired R2 actual=%0d expected=%0d", checks, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule